// File: doc/BRIEF.md
# Strip-Mining Vector Length Controller

This block steers a loop that carries out a vector operation of arbitrary length `n` in pieces that never exceed the machine's maximum vector length (MVL). A single start strobe, together with `n`, sets off the sequence. For each piece the block produces a vector length and the element offset where that piece begins. Downstream execution units read both values from registered outputs.

The short remainder piece (`n mod MVL` elements) is issued first. Every later piece has the full MVL length. If `n` is an exact multiple of MVL, the block issues no zero-length piece and starts directly with a full piece. Each piece is announced by a one-cycle valid pulse. The block then waits until the execution side returns a chunk-done pulse before it issues the next piece. After the last piece is acknowledged, it pulses `done_o`.

Top module: `strip_len_ctrl`

## Requirements
- R1: After reset, `chunk_valid_o`, `done_o` and `busy_o` are 0, and `vlen_o` and `offset_o` are 0.
- R2: When `start_i` is sampled high while idle with nonzero `n` not a multiple of MVL, `chunk_valid_o` pulses on the next cycle with `vlen_o = n mod MVL` (1 to MVL-1) and `offset_o = 0`.
- R3: When `n` is a nonzero multiple of MVL, the first piece has `vlen_o = MVL` and `offset_o = 0`.
- R4: Every piece after the first has `vlen_o = MVL`.
- R5: Each piece's `offset_o` equals the previous piece's `offset_o` plus the previous piece's `vlen_o`.
- R6: Exactly ceil(n/MVL) pieces are issued. `done_o` is high for one cycle, in the cycle after `chunk_done_i` is sampled for the last piece.
- R7: With `n = 0`, `done_o` pulses in the cycle after start, and no piece is issued.
- R8: A piece's valid pulse lasts one cycle. The next piece appears in the cycle after `chunk_done_i` is sampled, and never before that.
- R9: `vlen_o` and `offset_o` change only when a piece is issued. They hold between pieces and after `done_o`.
- R10: `busy_o` is high from the cycle after start until the piece sequence ends, and it is low while `done_o` is high. `start_i` is ignored while busy.
- R11: `chunk_done_i` has no effect while the block is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a new strip-mined loop (sampled when idle) |
| total_len_i | input | LEN_W | Total element count n, sampled with start |
| chunk_done_i | input | 1 | Execution side has finished the current piece |
| chunk_valid_o | output | 1 | One-cycle pulse: a new piece is presented |
| vlen_o | output | VL_W | Vector length register value for the current piece |
| offset_o | output | LEN_W | First element index of the current piece |
| busy_o | output | 1 | A sequence is in progress |
| done_o | output | 1 | One-cycle pulse: all pieces finished |

## Verification
The hardest situations to reach from the ports are overlapping strobes. One is a chunk-done that arrives in the same cycle as its valid pulse, which gives back-to-back pieces. The other is a start that arrives in the middle of a sequence and must be ignored. The stimulus covers both with random acknowledge delays of zero to three cycles and random spurious starts during waits. Directed lengths also cover zero, exact multiples, MVL±1 and the 200-element case (8 then three full pieces).

// File: rtl/strip_pkg.sv
package strip_pkg;
   typedef enum logic [0:0] {
      ST_IDLE = 1'b0,
      ST_WAIT = 1'b1
   } strip_state_e;
endpackage

// File: rtl/strip_first_len.sv
// Computes the length of the leading piece: the remainder, or a full
// piece when the remainder is zero. Flags an empty request.
module strip_first_len #(
   parameter int MAX_VL = 64,
   parameter int LEN_W  = 16,
   parameter int VL_W   = 7
) (
   input  logic [LEN_W-1:0] len_i,
   output logic [VL_W-1:0]  first_len_o,
   output logic             empty_o
);
   localparam int              LOG_MVL = $clog2(MAX_VL);
   localparam bit              IS_POW2 = ((1 << LOG_MVL) == MAX_VL);
   localparam logic [VL_W-1:0] MVL_V   = VL_W'(MAX_VL);

   logic [VL_W-1:0] rem_v;

   generate
      if (IS_POW2) begin : g_mask
         // power-of-two piece size: remainder is the low bits
         assign rem_v = VL_W'(len_i[LOG_MVL-1:0]);
      end else begin : g_mod
         logic [LEN_W-1:0] rem_full;
         assign rem_full = len_i % LEN_W'(MAX_VL);
         assign rem_v    = VL_W'(rem_full);
      end
   endgenerate

   assign first_len_o = (rem_v == '0) ? MVL_V : rem_v;
   assign empty_o     = (len_i == '0);
endmodule

// File: rtl/strip_seq_fsm.sv
// Sequencing core: tracks elements left after the current piece and
// produces the load/finish strobes.
module strip_seq_fsm
   import strip_pkg::*;
#(
   parameter int MAX_VL = 64,
   parameter int LEN_W  = 16,
   parameter int VL_W   = 7
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   input  logic [LEN_W-1:0] len_i,
   input  logic [VL_W-1:0]  first_len_i,
   input  logic             empty_i,
   input  logic             chunk_done_i,
   output logic             load_first_o,
   output logic             load_next_o,
   output logic             finish_o,
   output logic             busy_o
);
   localparam logic [LEN_W-1:0] MVL_L = LEN_W'(MAX_VL);

   strip_state_e     state_q;
   logic [LEN_W-1:0] left_q;
   logic             idle_start;
   logic             ack;

   assign idle_start   = (state_q == ST_IDLE) && start_i;
   assign ack          = (state_q == ST_WAIT) && chunk_done_i;
   assign load_first_o = idle_start && !empty_i;
   assign load_next_o  = ack && (left_q != '0);
   assign finish_o     = (idle_start && empty_i) || (ack && (left_q == '0));
   assign busy_o       = (state_q == ST_WAIT);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         left_q  <= '0;
      end else begin
         if (load_first_o) begin
            state_q <= ST_WAIT;
            left_q  <= len_i - LEN_W'(first_len_i);
         end else if (load_next_o) begin
            left_q  <= left_q - MVL_L;
         end else if (ack) begin
            state_q <= ST_IDLE;
         end
      end
   end
endmodule

// File: rtl/strip_vl_reg.sv
// Output registers: vector length, offset, valid and done pulses.
module strip_vl_reg #(
   parameter int MAX_VL = 64,
   parameter int LEN_W  = 16,
   parameter int VL_W   = 7
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load_first_i,
   input  logic             load_next_i,
   input  logic             finish_i,
   input  logic [VL_W-1:0]  first_len_i,
   output logic [VL_W-1:0]  vlen_o,
   output logic [LEN_W-1:0] offset_o,
   output logic             valid_o,
   output logic             done_o
);
   localparam logic [VL_W-1:0] MVL_V = VL_W'(MAX_VL);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vlen_o   <= '0;
         offset_o <= '0;
         valid_o  <= 1'b0;
         done_o   <= 1'b0;
      end else begin
         valid_o <= load_first_i || load_next_i;
         done_o  <= finish_i;
         if (load_first_i) begin
            vlen_o   <= first_len_i;
            offset_o <= '0;
         end else if (load_next_i) begin
            vlen_o   <= MVL_V;
            offset_o <= offset_o + LEN_W'(vlen_o);
         end
      end
   end
endmodule

// File: rtl/strip_len_ctrl.sv
module strip_len_ctrl #(
   parameter int MAX_VL = 64,
   parameter int LEN_W  = 16,
   parameter int VL_W   = $clog2(MAX_VL + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   input  logic [LEN_W-1:0] total_len_i,
   input  logic             chunk_done_i,
   output logic             chunk_valid_o,
   output logic [VL_W-1:0]  vlen_o,
   output logic [LEN_W-1:0] offset_o,
   output logic             busy_o,
   output logic             done_o
);
   generate
      if (MAX_VL < 2) begin : g_bad_mvl
         $error("strip_len_ctrl: MAX_VL must be at least 2");
      end
      if (VL_W < $clog2(MAX_VL + 1)) begin : g_bad_vlw
         $error("strip_len_ctrl: VL_W too narrow for MAX_VL");
      end
      if (LEN_W < VL_W) begin : g_bad_lenw
         $error("strip_len_ctrl: LEN_W must be at least VL_W");
      end
   endgenerate

   logic [VL_W-1:0] first_len;
   logic            empty;
   logic            load_first;
   logic            load_next;
   logic            finish;

   strip_first_len #(.MAX_VL(MAX_VL), .LEN_W(LEN_W), .VL_W(VL_W)) u_first (
      .len_i       (total_len_i),
      .first_len_o (first_len),
      .empty_o     (empty)
   );

   strip_seq_fsm #(.MAX_VL(MAX_VL), .LEN_W(LEN_W), .VL_W(VL_W)) u_fsm (
      .clk          (clk),
      .rst_n        (rst_n),
      .start_i      (start_i),
      .len_i        (total_len_i),
      .first_len_i  (first_len),
      .empty_i      (empty),
      .chunk_done_i (chunk_done_i),
      .load_first_o (load_first),
      .load_next_o  (load_next),
      .finish_o     (finish),
      .busy_o       (busy_o)
   );

   strip_vl_reg #(.MAX_VL(MAX_VL), .LEN_W(LEN_W), .VL_W(VL_W)) u_regs (
      .clk          (clk),
      .rst_n        (rst_n),
      .load_first_i (load_first),
      .load_next_i  (load_next),
      .finish_i     (finish),
      .first_len_i  (first_len),
      .vlen_o       (vlen_o),
      .offset_o     (offset_o),
      .valid_o      (chunk_valid_o),
      .done_o       (done_o)
   );
endmodule

// File: rtl/strip_len_ctrl_chk.sv
module strip_len_ctrl_chk #(
   parameter int MAX_VL = 64,
   parameter int LEN_W  = 16,
   parameter int VL_W   = 7
) (
   input logic             clk,
   input logic             rst_n,
   input logic             start_i,
   input logic             chunk_done_i,
   input logic             chunk_valid_o,
   input logic [VL_W-1:0]  vlen_o,
   input logic [LEN_W-1:0] offset_o,
   input logic             busy_o,
   input logic             done_o
);
   localparam logic [VL_W-1:0] MVL_V = VL_W'(MAX_VL);

   logic [LEN_W-1:0] prev_off;
   logic [VL_W-1:0]  prev_vl;
   logic [LEN_W-1:0] off_step;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_off <= '0;
         prev_vl  <= '0;
      end else begin
         prev_off <= offset_o;
         prev_vl  <= vlen_o;
      end
   end
   assign off_step = prev_off + LEN_W'(prev_vl);

   AST_VLEN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      chunk_valid_o |-> (vlen_o != '0) && (vlen_o <= MVL_V)); // R2
   AST_LATER_FULL: assert property (@(posedge clk) disable iff (!rst_n)
      (chunk_valid_o && offset_o != '0) |-> (vlen_o == MVL_V)); // R4
   AST_OFFSET_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (chunk_valid_o && offset_o != '0) |-> (offset_o == off_step)); // R5
   AST_NO_VALID_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      !(done_o && chunk_valid_o)); // R7
   AST_VALID_TRIGGER: assert property (@(posedge clk) disable iff (!rst_n)
      chunk_valid_o |-> ($past(start_i && !busy_o) || $past(chunk_done_i && busy_o))); // R8
   AST_HOLD_OUTPUTS: assert property (@(posedge clk) disable iff (!rst_n)
      !chunk_valid_o |-> ($stable(vlen_o) && $stable(offset_o))); // R9
   AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> !busy_o); // R10
   AST_VALID_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      chunk_valid_o |-> busy_o); // R10
endmodule

bind strip_len_ctrl strip_len_ctrl_chk #(
   .MAX_VL(MAX_VL), .LEN_W(LEN_W), .VL_W(VL_W)
) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .start_i       (start_i),
   .chunk_done_i  (chunk_done_i),
   .chunk_valid_o (chunk_valid_o),
   .vlen_o        (vlen_o),
   .offset_o      (offset_o),
   .busy_o        (busy_o),
   .done_o        (done_o)
);

// File: tb/strip_len_ctrl_tb.sv
module strip_len_ctrl_tb;
   localparam int CLK_PERIOD = 10;
   localparam int MAX_VL     = 64;
   localparam int LEN_W      = 16;
   localparam int VL_W       = $clog2(MAX_VL + 1);

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             start_i = 1'b0;
   logic [LEN_W-1:0] total_len_i = '0;
   logic             chunk_done_i = 1'b0;
   logic             chunk_valid_o;
   logic [VL_W-1:0]  vlen_o;
   logic [LEN_W-1:0] offset_o;
   logic             busy_o;
   logic             done_o;

   int checks = 0;
   int errors = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   strip_len_ctrl #(.MAX_VL(MAX_VL), .LEN_W(LEN_W)) u_dut (
      .clk           (clk),
      .rst_n         (rst_n),
      .start_i       (start_i),
      .total_len_i   (total_len_i),
      .chunk_done_i  (chunk_done_i),
      .chunk_valid_o (chunk_valid_o),
      .vlen_o        (vlen_o),
      .offset_o      (offset_o),
      .busy_o        (busy_o),
      .done_o        (done_o)
   );

   function automatic int exp_pieces(int n);
      return (n + MAX_VL - 1) / MAX_VL;
   endfunction

   function automatic int exp_len(int n, int k);
      if (k == 0 && (n % MAX_VL) != 0) return n % MAX_VL;
      return MAX_VL;
   endfunction

   task automatic chk(input string req, input longint act, input longint exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic run_case(input int n, input int max_wait, input bit noisy);
      int off_exp = 0;
      int np = exp_pieces(n);
      int last_vl = int'(vlen_o);
      int last_off = int'(offset_o);
      start_i     = 1'b1;
      total_len_i = LEN_W'(n);
      @(negedge clk);
      start_i     = 1'b0;
      total_len_i = LEN_W'($urandom % 2000);
      if (n == 0) begin
         chk("R7 done after zero-length start", done_o, 1);
         chk("R7 no piece for zero length", chunk_valid_o, 0);
         chk("R9 vlen held on zero length", vlen_o, last_vl);
         chk("R9 offset held on zero length", offset_o, last_off);
         @(negedge clk);
         chk("R6 done is a single pulse", done_o, 0);
         return;
      end
      for (int k = 0; k < np; k++) begin
         int el = exp_len(n, k);
         int d  = $urandom % (max_wait + 1);
         chk("R8 piece valid", chunk_valid_o, 1);
         if (k == 0 && (n % MAX_VL) == 0)
            chk("R3 first piece full on exact multiple", vlen_o, el);
         else if (k == 0)
            chk("R2 first piece is remainder", vlen_o, el);
         else
            chk("R4 later piece full", vlen_o, el);
         chk("R5 piece offset", offset_o, off_exp);
         chk("R10 busy during sequence", busy_o, 1);
         for (int w = 0; w < d; w++) begin
            if (noisy && ($urandom % 2) == 1) start_i = 1'b1;
            @(negedge clk);
            start_i = 1'b0;
            chk("R8 no piece before chunk done", chunk_valid_o, 0);
            chk("R9 vlen held while waiting", vlen_o, el);
            chk("R9 offset held while waiting", offset_o, off_exp);
            chk("R10 start ignored while busy", busy_o, 1);
         end
         chunk_done_i = 1'b1;
         @(negedge clk);
         chunk_done_i = 1'b0;
         off_exp += el;
      end
      chk("R6 done after last piece", done_o, 1);
      chk("R6 no extra piece", chunk_valid_o, 0);
      chk("R10 busy low with done", busy_o, 0);
      @(negedge clk);
      chk("R6 done is a single pulse", done_o, 0);
      chk("R9 vlen held after done", vlen_o, exp_len(n, np - 1));
      chk("R9 offset held after done", offset_o, off_exp - exp_len(n, np - 1));
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      void'($urandom(32'h5EED_0042));
      repeat (3) @(negedge clk);
      // R1 reset state
      chk("R1 valid at reset", chunk_valid_o, 0);
      chk("R1 done at reset", done_o, 0);
      chk("R1 busy at reset", busy_o, 0);
      chk("R1 vlen at reset", vlen_o, 0);
      chk("R1 offset at reset", offset_o, 0);
      rst_n = 1'b1;
      @(negedge clk);
      // R11 chunk done while idle is ignored
      chunk_done_i = 1'b1;
      @(negedge clk);
      chunk_done_i = 1'b0;
      chk("R11 no piece from idle chunk done", chunk_valid_o, 0);
      chk("R11 no done from idle chunk done", done_o, 0);
      chk("R11 still idle", busy_o, 0);
      // directed corners
      run_case(200, 0, 1'b0);
      run_case(200, 3, 1'b1);
      run_case(0, 0, 1'b0);
      run_case(64, 2, 1'b0);
      run_case(128, 0, 1'b0);
      run_case(1, 1, 1'b0);
      run_case(63, 2, 1'b1);
      run_case(65, 1, 1'b1);
      run_case(0, 0, 1'b0);
      // random
      for (int i = 0; i < 60; i++) begin
         int n = ($urandom % 4 == 0) ? MAX_VL * ($urandom % 8) : $urandom % 1200;
         run_case(n, $urandom % 4, $urandom % 2 == 1);
         repeat ($urandom % 3) @(negedge clk);
      end
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule